// File: doc/BRIEF.md
# Signed-Digit Stream Linearity Corrector

This block sits behind a cyclic converter that resolves one redundant signed digit per cycle, most significant first. Each digit is +1, 0 or -1, and several digit strings may stand for the same value. The block turns the digit stream into a two's-complement sample while it arrives. It also removes three analog errors that a calibration step has measured beforehand: the gain error of the doubling stage, the scale error of the reference add/subtract, and the input offset.

A sample-start strobe captures three signed fixed-point coefficients (16 fractional bits). These are the weight scale 1+β, the half doubling error ε/2 and the offset. For each accepted digit the running weight is halved, and an error term tracks the first-order loss i·ε/2 of the i-th weight. The digit then adds or subtracts the corrected weight into an accumulator. After the last digit, the accumulator is scaled to the output width, clamped to the signed output range and presented for one cycle with a valid strobe.

Top module: `rsd_lin_corrector`

## Requirements
- R1: Digit code 2'b01 means +1 and adds the step term, 2'b11 means -1 and subtracts it, and codes 2'b00 and 2'b10 both mean 0 and leave the accumulator unchanged.
- R2: On the edge that samples `sample_start`, the weight register W takes `gain_coef`, the error register E takes 0, the slope register K takes `slope_coef` and the accumulator takes minus `offset_coef`. Later changes on the coefficient inputs have no effect on that conversion.
- R3: Each accepted digit computes W' = W>>>1 and E' = (E + ((K·W)>>>16))>>>1 from the old W and E, with all shifts arithmetic. It then applies the term W' - E' under R1 and stores W', E'.
- R4: The result is the final accumulator shifted right arithmetically by 16-(OUT_W-1) bits, clamped to [-2^(OUT_W-1), 2^(OUT_W-1)-1]. It holds between valid strobes.
- R5: `result_valid` is high for exactly one cycle, starting on the second rising edge after the edge that accepts the N_DIGITS-th digit.
- R6: A digit is accepted only when `digit_valid` is high during a conversion. Digits offered after N_DIGITS have been taken, or before any start, change neither output.
- R7: A start during a conversion discards the partial sum and reloads all registers. In a cycle with both strobes high, the start wins and the digit is dropped.
- R8: Reset, synchronous and active high, clears `result` to 0 and `result_valid` to 0 and leaves the block idle.
- R9: With `gain_coef` = 65536 and `slope_coef` = 0, different digit strings of equal value give equal results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_start | input | 1 | Begins a conversion and captures coefficients |
| digit_valid | input | 1 | Marks `digit` as carrying a digit this cycle |
| digit | input | 2 | Signed digit code (R1) |
| gain_coef | input | COEF_W | Weight scale 1+β, 16 fractional bits |
| slope_coef | input | COEF_W | Half doubling error ε/2, 16 fractional bits |
| offset_coef | input | COEF_W | Offset to remove, 16 fractional bits |
| result | output | OUT_W | Corrected, saturated two's-complement sample |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The bench uses the defaults: 14 digits, 18-bit coefficients, a 20-bit datapath and a 16-bit result. These values leave one output bit of shift, so an all-ones or all-minus-ones digit string with a weight scale of 1.5 drives the sum past both clamp limits. A 16-cycle conversion also leaves room to restart part way and to offer stray digits after completion. Non-zero slope and offset coefficients exercise the error-term recurrence, and zero-error runs expose redundant strings of equal value.

// File: rtl/rsd_corr_pkg.sv
package rsd_corr_pkg;

    typedef enum logic [1:0] {
        DIG_ZERO     = 2'b00,
        DIG_POS      = 2'b01,
        DIG_ALT_ZERO = 2'b10,
        DIG_NEG      = 2'b11
    } rsd_digit_e;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2
    } acc_op_e;

    typedef struct packed {
        logic load;   // reload coefficients and clear partial sum
        logic step;   // a digit is accepted this cycle
        logic fin;    // the last digit was accepted on the previous edge
    } seq_ctl_t;

    function automatic acc_op_e decode_digit(input logic [1:0] d);
        case (rsd_digit_e'(d))
            DIG_POS: return ACC_ADD;
            DIG_NEG: return ACC_SUB;
            default: return ACC_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/rsd_seq_ctrl.sv
module rsd_seq_ctrl
    import rsd_corr_pkg::*;
#(
    parameter int N_DIGITS = 14
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sample_start,
    input  logic     digit_valid,
    output seq_ctl_t ctl
);
    localparam int CNT_W = $clog2(N_DIGITS + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fin_q;
    logic             last;

    assign last     = (cnt_q == CNT_W'(N_DIGITS - 1));
    assign ctl.load = sample_start;
    assign ctl.step = digit_valid && busy_q && !sample_start;
    assign ctl.fin  = fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= ctl.step && last;
            if (sample_start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (ctl.step) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rsd_weight_track.sv
module rsd_weight_track
    import rsd_corr_pkg::*;
#(
    parameter int COEF_W = 18,
    parameter int FRAC   = 16,
    parameter int DW     = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  seq_ctl_t                 ctl,
    input  logic signed [COEF_W-1:0] gain_coef,
    input  logic signed [COEF_W-1:0] slope_coef,
    output logic signed [DW-1:0]     term
);
    localparam int EXT = DW - COEF_W;

    logic signed [DW-1:0]   w_q, e_q, k_q;
    logic signed [DW-1:0]   w_nx, e_nx, kw, e_sum;
    logic signed [2*DW-1:0] prod;

    assign prod  = k_q * w_q;
    assign kw    = DW'(prod >>> FRAC);
    assign e_sum = e_q + kw;
    assign e_nx  = e_sum >>> 1;
    assign w_nx  = w_q >>> 1;
    assign term  = w_nx - e_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '0;
            e_q <= '0;
            k_q <= '0;
        end else if (ctl.load) begin
            w_q <= {{EXT{gain_coef[COEF_W-1]}}, gain_coef};
            k_q <= {{EXT{slope_coef[COEF_W-1]}}, slope_coef};
            e_q <= '0;
        end else if (ctl.step) begin
            w_q <= w_nx;
            e_q <= e_nx;
        end
    end
endmodule

// File: rtl/rsd_accum.sv
module rsd_accum
    import rsd_corr_pkg::*;
#(
    parameter int COEF_W = 18,
    parameter int DW     = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  seq_ctl_t                 ctl,
    input  logic [1:0]               digit,
    input  logic signed [DW-1:0]     term,
    input  logic signed [COEF_W-1:0] offset_coef,
    output logic signed [DW-1:0]     acc
);
    localparam int EXT = DW - COEF_W;

    acc_op_e              op;
    logic signed [DW-1:0] off_ext;

    assign op      = decode_digit(digit);
    assign off_ext = {{EXT{offset_coef[COEF_W-1]}}, offset_coef};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (ctl.load) begin
            acc <= -off_ext;
        end else if (ctl.step) begin
            case (op)
                ACC_ADD: acc <= acc + term;
                ACC_SUB: acc <= acc - term;
                default: acc <= acc;
            endcase
        end
    end
endmodule

// File: rtl/rsd_sat_out.sv
module rsd_sat_out
    import rsd_corr_pkg::*;
#(
    parameter int FRAC  = 16,
    parameter int DW    = 20,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  seq_ctl_t                ctl,
    input  logic signed [DW-1:0]    acc,
    output logic signed [OUT_W-1:0] result,
    output logic                    result_valid
);
    localparam int SHIFT = FRAC - (OUT_W - 1);
    localparam logic signed [DW-1:0] MAXV =
        $signed({{(DW - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}});
    localparam logic signed [DW-1:0] MINV = ~MAXV;

    logic signed [DW-1:0]    scaled;
    logic signed [OUT_W-1:0] clamped;

    assign scaled = acc >>> SHIFT;

    always_comb begin
        if (scaled > MAXV) begin
            clamped = MAXV[OUT_W-1:0];
        end else if (scaled < MINV) begin
            clamped = MINV[OUT_W-1:0];
        end else begin
            clamped = scaled[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= ctl.fin;
            if (ctl.fin) begin
                result <= clamped;
            end
        end
    end
endmodule

// File: rtl/rsd_lin_corrector.sv
module rsd_lin_corrector
    import rsd_corr_pkg::*;
#(
    parameter int N_DIGITS = 14,
    parameter int COEF_W   = 18,
    parameter int FRAC     = 16,
    parameter int DW       = 20,
    parameter int OUT_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_start,
    input  logic                     digit_valid,
    input  logic [1:0]               digit,
    input  logic signed [COEF_W-1:0] gain_coef,
    input  logic signed [COEF_W-1:0] slope_coef,
    input  logic signed [COEF_W-1:0] offset_coef,
    output logic signed [OUT_W-1:0]  result,
    output logic                     result_valid
);
    seq_ctl_t             ctl;
    logic signed [DW-1:0] term;
    logic signed [DW-1:0] acc;

    rsd_seq_ctrl #(.N_DIGITS(N_DIGITS)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sample_start (sample_start),
        .digit_valid  (digit_valid),
        .ctl          (ctl)
    );

    rsd_weight_track #(.COEF_W(COEF_W), .FRAC(FRAC), .DW(DW)) u_weight (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .gain_coef  (gain_coef),
        .slope_coef (slope_coef),
        .term       (term)
    );

    rsd_accum #(.COEF_W(COEF_W), .DW(DW)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .digit       (digit),
        .term        (term),
        .offset_coef (offset_coef),
        .acc         (acc)
    );

    rsd_sat_out #(.FRAC(FRAC), .DW(DW), .OUT_W(OUT_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .ctl          (ctl),
        .acc          (acc),
        .result       (result),
        .result_valid (result_valid)
    );
endmodule

// File: rtl/rsd_lin_corrector_chk.sv
module rsd_lin_corrector_chk #(
    parameter int N_DIGITS = 14,
    parameter int OUT_W    = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sample_start,
    input logic                    digit_valid,
    input logic signed [OUT_W-1:0] result,
    input logic                    result_valid
);
    localparam int CNT_W = $clog2(N_DIGITS + 1);

    // Port-level model of conversion progress, kept apart from the design.
    logic             m_busy;
    logic [CNT_W-1:0] m_cnt;
    logic             m_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0;
            m_cnt  <= '0;
            m_done <= 1'b0;
        end else begin
            m_done <= 1'b0;
            if (sample_start) begin
                m_busy <= 1'b1;
                m_cnt  <= '0;
            end else if (m_busy && digit_valid) begin
                if (m_cnt == CNT_W'(N_DIGITS - 1)) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                end
                m_cnt <= m_cnt + 1'b1;
            end
        end
    end

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    assert_valid_timing_R5: assert property (@(posedge clk) disable iff (rst)
        m_done |=> result_valid);

    assert_no_stray_valid_R6: assert property (@(posedge clk) disable iff (rst)
        !m_done |=> !result_valid);

    assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        sample_start |=> !result_valid);

    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (!result_valid && result == '0));
endmodule

bind rsd_lin_corrector rsd_lin_corrector_chk #(
    .N_DIGITS (N_DIGITS),
    .OUT_W    (OUT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_start (sample_start),
    .digit_valid  (digit_valid),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/sim_rsd_lin_corrector.sv
module sim_rsd_lin_corrector;
    localparam int N    = 14;
    localparam int CW   = 18;
    localparam int OW   = 16;
    localparam int FRAC = 16;

    typedef struct packed {
        logic [2*N-1:0] dg;   // digit i in bits [2*i+1:2*i], i = 0 first
        logic [31:0]    g;
        logic [31:0]    k;
        logic [31:0]    o;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{28'h0000000, 32'd65536, 32'd0,   32'd0},
        '{28'h0000001, 32'd65536, 32'd0,   32'd0},
        '{28'h5A5A5A5, 32'd66000, 32'd131, 32'd50},
        '{28'hF3C0F3C, 32'd65200, 32'd200, -32'sd300},
        '{28'h1D7B3E1, 32'd65800, -32'sd90, 32'd1200},
        '{28'hAAAAAAA, 32'd65536, 32'd262, 32'd0}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sample_start = 1'b0;
    logic                 digit_valid = 1'b0;
    logic [1:0]           digit = 2'b00;
    logic signed [CW-1:0] gain_coef = '0;
    logic signed [CW-1:0] slope_coef = '0;
    logic signed [CW-1:0] offset_coef = '0;
    logic signed [OW-1:0] result;
    logic                 result_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rsd_lin_corrector u0 (
        .clk          (clk),
        .rst          (rst),
        .sample_start (sample_start),
        .digit_valid  (digit_valid),
        .digit        (digit),
        .gain_coef    (gain_coef),
        .slope_coef   (slope_coef),
        .offset_coef  (offset_coef),
        .result       (result),
        .result_valid (result_valid)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected value from the recurrence stated in R1..R4.
    function automatic longint model(input logic [2*N-1:0] dg, input longint g,
                                     input longint k, input longint o);
        longint w = g;
        longint e = 0;
        longint a = -o;
        longint r;
        for (int i = 0; i < N; i++) begin
            longint wn = w >>> 1;
            longint en = (e + ((k * w) >>> FRAC)) >>> 1;
            longint t = wn - en;
            if (dg[2*i +: 2] == 2'b01) a = a + t;
            else if (dg[2*i +: 2] == 2'b11) a = a - t;
            w = wn;
            e = en;
        end
        r = a >>> (FRAC - (OW - 1));
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic set_coef(input longint g, input longint k, input longint o);
        gain_coef   = CW'(g);
        slope_coef  = CW'(k);
        offset_coef = CW'(o);
    endtask

    // Feed N digits after a start already sampled; optionally disturb coefficients (R2).
    task automatic feed(input logic [2*N-1:0] dg, input bit wiggle);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            sample_start = 1'b0;
            digit_valid  = 1'b1;
            digit        = dg[2*i +: 2];
            if (wiggle) set_coef(70000 + i * 17, 900 - i, -4000 + i);
        end
    endtask

    // After the last digit: check the R5 timing, then the value.
    task automatic finish_conv(input string req, input longint exp);
        @(negedge clk);
        digit_valid = 1'b0;
        chk("R5 valid low one cycle after last digit", longint'(result_valid), 0);
        @(negedge clk);
        chk("R5 valid high two cycles after last digit", longint'(result_valid), 1);
        chk(req, longint'(result), exp);
        @(negedge clk);
        chk("R5 valid is a single pulse", longint'(result_valid), 0);
        chk("R4 result holds after strobe", longint'(result), exp);
    endtask

    task automatic conv(input string req, input logic [2*N-1:0] dg, input longint g,
                        input longint k, input longint o, input longint exp);
        @(negedge clk);
        sample_start = 1'b1;
        digit_valid  = 1'b0;
        set_coef(g, k, o);
        feed(dg, 1'b0);
        finish_conv(req, exp);
    endtask

    initial begin
        longint keep;
        repeat (3) @(negedge clk);
        chk("R8 reset result", longint'(result), 0);
        chk("R8 reset valid", longint'(result_valid), 0);
        rst = 1'b0;

        // R6: digits before any start are ignored
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            digit_valid = 1'b1;
            digit = 2'b01;
        end
        @(negedge clk);
        digit_valid = 1'b0;
        @(negedge clk);
        chk("R6 no valid before start", longint'(result_valid), 0);
        chk("R6 result untouched before start", longint'(result), 0);

        // Vector table: R1, R2, R3, R4
        for (int v = 0; v < NV; v++) begin
            conv("R3 table vector result", VEC[v].dg, longint'($signed(VEC[v].g)),
                 longint'($signed(VEC[v].k)), longint'($signed(VEC[v].o)),
                 model(VEC[v].dg, longint'($signed(VEC[v].g)),
                       longint'($signed(VEC[v].k)), longint'($signed(VEC[v].o))));
        end

        // R1: hand values, code 10 behaves as zero
        conv("R1 single +1 first digit", 28'h0000001, 65536, 0, 0, 16384);
        conv("R1 single -1 first digit", 28'h0000003, 65536, 0, 0, -16384);
        conv("R1 code 10 is zero", 28'h0000002, 65536, 0, 0, 0);

        // R9: redundant strings of equal value
        conv("R9 string 0,+1", 28'h0000004, 65536, 0, 0, 8192);
        conv("R9 string +1,-1", 28'h000000D, 65536, 0, 0, 8192);

        // R4: clamp at both ends
        conv("R4 positive clamp", 28'h5555555, 98304, 0, 0, 32767);
        conv("R4 negative clamp", 28'hFFFFFFF, 98304, 0, 0, -32768);

        // R2: offset is removed; coefficient changes after start are ignored
        conv("R2 offset only", 28'h0000000, 65536, 0, 2000, -1000);
        @(negedge clk);
        sample_start = 1'b1;
        set_coef(66000, 131, 50);
        feed(28'h5A5A5A5, 1'b1);
        finish_conv("R2 coefficients captured at start",
                    model(28'h5A5A5A5, 66000, 131, 50));

        // R6: digits after completion are ignored
        keep = longint'(result);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            digit_valid = 1'b1;
            digit = 2'b11;
            chk("R6 no valid after completion", longint'(result_valid), 0);
        end
        @(negedge clk);
        digit_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 result unchanged by stray digits", longint'(result), keep);

        // R7: restart mid-conversion, start beats a digit in the same cycle
        @(negedge clk);
        sample_start = 1'b1;
        set_coef(98304, 0, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sample_start = 1'b0;
            digit_valid = 1'b1;
            digit = 2'b01;
        end
        @(negedge clk);
        sample_start = 1'b1;
        digit_valid = 1'b1;
        digit = 2'b01;
        set_coef(65200, 200, -300);
        chk("R7 no valid from abandoned run", longint'(result_valid), 0);
        feed(28'hF3C0F3C, 1'b0);
        finish_conv("R7 restart result", model(28'hF3C0F3C, 65200, 200, -300));

        // R8: reset mid-run clears outputs
        @(negedge clk);
        sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R8 reset clears result", longint'(result), 0);
        chk("R8 reset clears valid", longint'(result_valid), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule